// File: doc/BRIEF.md
# Stereo Digital Volume With Synchronized Update

This block scales a stereo stream of signed audio samples by a gain chosen per channel with an 8-bit logarithmic code. Each code step is 0.375 dB. Code 0x00 silences the channel, 0x01 is the quietest audible setting, 0xC0 is unity and 0xEF is the loudest. Codes above 0xEF act as 0xEF. Each channel also has an enable. A disabled channel sends out zeros while samples keep flowing.

Software writes new codes into a staging register per channel. Staged codes change nothing until an update request arrives. The request may come through the write of either channel, and it then moves both staged codes into service together. The change happens on the first sample that arrives after the request, so no sample is ever scaled by a half-updated setting. The request clears itself. Inside the block the gain is a 16-entry fractional mantissa, covering one 6 dB octave, combined with a power-of-two shift taken from the top four code bits. The block multiplies, rounds and saturates over two pipeline stages.

Top module: `stereo_volume`

## Requirements
- R1: While reset is held and at the first falling edge after it is released, `outValid`, `outLeft` and `outRight` are all 0.
- R2: After reset the active code of both channels is 0xC0, so an enabled channel with no update ever requested outputs its input unchanged.
- R3: A sample presented with `inValid` high on rising edge n appears on the outputs with `outValid` high after edge n+2. `outValid` is low in every cycle that has no such sample.
- R4: For an active code c from 0x01 to 0xEF: let hi = c[7:4], k = c[3:0], M(k) = round(2^(k/16)·2^14) and s = 26 − hi. The output is floor((x·M(k) + 2^(s−1)) / 2^s), where x is the signed input sample.
- R5: A result outside the signed sample range is clamped to −2^(W−1) or 2^(W−1)−1.
- R6: Active code 0x00 forces that channel's output to 0.
- R7: Active codes 0xF0 to 0xFF give exactly the output of code 0xEF.
- R8: A channel write with its update bit clear changes only the staged code and the enable. The active gain of both channels stays as it was.
- R9: A write to either channel with the update bit set makes both channels' staged codes active together.
- R10: After an update request, the first sample whose `inValid` cycle comes strictly after the request cycle takes the staged codes as they are in its own cycle. A sample in the same cycle as the request still uses the old codes.
- R11: The update request is consumed by that one commit. Later writes with the update bit clear do not reach the active gain.
- R12: Enables are low after reset. A write sets a channel's enable to the value on its enable input, and the change applies to samples in later cycles. A disabled channel outputs 0 while `outValid` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| leftWr | input | 1 | Left channel register write strobe |
| leftWrEna | input | 1 | Enable value written to the left channel |
| leftWrUpd | input | 1 | Update request carried by the left write |
| leftWrCode | input | 8 | Volume code staged for the left channel |
| rightWr | input | 1 | Right channel register write strobe |
| rightWrEna | input | 1 | Enable value written to the right channel |
| rightWrUpd | input | 1 | Update request carried by the right write |
| rightWrCode | input | 8 | Volume code staged for the right channel |
| inValid | input | 1 | Input sample pair valid |
| inLeft | input | SAMPLE_W | Left input sample, two's complement |
| inRight | input | SAMPLE_W | Right input sample, two's complement |
| outValid | output | 1 | Output sample pair valid |
| outLeft | output | SAMPLE_W | Scaled left sample |
| outRight | output | SAMPLE_W | Scaled right sample |

## Verification
The overlap of interest is a register write and an input sample in the same cycle. An update request or an enable change can meet a sample that is already being accepted. The bench drives a write carrying the update bit together with `inValid`. It expects that sample to leave with the old gain and the next sample with the new gain. It then repeats the test with an enable being cleared. Every code from 0x00 to 0xFF is swept on both channels against extreme and ordinary samples, and the expected outputs are computed from the formula in R4.

// File: rtl/vol_pkg.sv
`timescale 1ns/1ps
package vol_pkg;
  localparam int NUM_CH = 2;
  localparam int CODE_W = 8;
  localparam int MANT_FRAC = 14;
  localparam int MANT_W = MANT_FRAC + 2;
  localparam int SHIFT_W = 5;
  localparam logic [CODE_W-1:0] UNITY_CODE = 8'hC0;
  localparam logic [CODE_W-1:0] TOP_CODE = 8'hEF;
  localparam logic [CODE_W-1:0] MUTE_CODE = 8'h00;
  localparam int SHIFT_BASE = MANT_FRAC + int'(UNITY_CODE >> 4);

  // Control to datapath: per-sample take strobe plus the gain settings in force for it
  typedef struct packed {
    logic take;
    logic [NUM_CH-1:0] ena;
    logic [NUM_CH-1:0][CODE_W-1:0] code;
  } volCmd_t;
endpackage

// File: rtl/vol_gain_decode.sv
`timescale 1ns/1ps
module vol_gain_decode
  import vol_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  output logic               isMute,
  output logic [MANT_W-1:0]  mant,
  output logic [SHIFT_W-1:0] shift
);
  logic [CODE_W-1:0] clamped;
  logic [3:0] octave;
  logic [3:0] step;

  always_comb begin
    clamped = (code > TOP_CODE) ? TOP_CODE : code;
    octave  = clamped[7:4];
    step    = clamped[3:0];
    isMute  = (code == MUTE_CODE);
    shift   = SHIFT_W'(SHIFT_BASE - int'(octave));
  end

  // 2^(step/16) in fixed point with MANT_FRAC fraction bits, rounded to nearest
  always_comb begin
    unique case (step)
      4'd0:  mant = MANT_W'(16384);
      4'd1:  mant = MANT_W'(17109);
      4'd2:  mant = MANT_W'(17867);
      4'd3:  mant = MANT_W'(18658);
      4'd4:  mant = MANT_W'(19484);
      4'd5:  mant = MANT_W'(20347);
      4'd6:  mant = MANT_W'(21247);
      4'd7:  mant = MANT_W'(22188);
      4'd8:  mant = MANT_W'(23170);
      4'd9:  mant = MANT_W'(24196);
      4'd10: mant = MANT_W'(25268);
      4'd11: mant = MANT_W'(26386);
      4'd12: mant = MANT_W'(27554);
      4'd13: mant = MANT_W'(28774);
      4'd14: mant = MANT_W'(30048);
      default: mant = MANT_W'(31379);
    endcase
  end
endmodule

// File: rtl/vol_ctrl.sv
`timescale 1ns/1ps
module vol_ctrl
  import vol_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0]              wrStb,
  input  logic [NUM_CH-1:0]              wrEna,
  input  logic [NUM_CH-1:0]              wrUpd,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  wrCode,
  input  logic                           sampleStb,
  output volCmd_t                        cmd,
  output logic [NUM_CH-1:0][CODE_W-1:0]  activeCode,
  output logic                           pending
);
  logic [NUM_CH-1:0][CODE_W-1:0] stagedCode;
  logic [NUM_CH-1:0] enaQ;
  logic updReq;
  logic commit;

  always_comb begin
    updReq = |(wrStb & wrUpd);
    commit = sampleStb & pending;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stagedCode[ch] <= UNITY_CODE;
        enaQ[ch]       <= 1'b0;
        activeCode[ch] <= UNITY_CODE;
      end else begin
        if (wrStb[ch]) begin
          stagedCode[ch] <= wrCode[ch];
          enaQ[ch]       <= wrEna[ch];
        end
        if (commit) activeCode[ch] <= stagedCode[ch];
      end
    end
  end

  // Update request waits for the next sample, then clears itself
  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= updReq | (pending & ~sampleStb);
  end

  always_comb begin
    cmd.take = sampleStb;
    cmd.ena  = enaQ;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      cmd.code[ch] = pending ? stagedCode[ch] : activeCode[ch];
    end
  end
endmodule

// File: rtl/vol_datapath.sv
`timescale 1ns/1ps
module vol_datapath
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  volCmd_t                          cmd,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  inSmp,
  output logic                             outValid,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]  outSmp
);
  localparam int PROD_W = SAMPLE_W + MANT_W + 1;
  localparam logic signed [PROD_W-1:0] SAT_HI =
    {{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] SAT_LO =
    {{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= cmd.take;
      outValid   <= stageValid;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic               decMute;
    logic [MANT_W-1:0]  decMant;
    logic [SHIFT_W-1:0] decShift;

    logic signed [SAMPLE_W-1:0] smpQ;
    logic [MANT_W-1:0]          mantQ;
    logic [SHIFT_W-1:0]         shiftQ;
    logic                       zeroQ;

    logic signed [PROD_W-1:0] smpExt;
    logic signed [PROD_W-1:0] mantExt;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] bias;
    logic signed [PROD_W-1:0] sum;
    logic signed [PROD_W-1:0] scaled;
    logic [SAMPLE_W-1:0]      result;

    vol_gain_decode u_dec (
      .code  (cmd.code[ch]),
      .isMute(decMute),
      .mant  (decMant),
      .shift (decShift)
    );

    // Stage 1: capture the sample together with the gain it must use
    always_ff @(posedge clk) begin
      if (!rstN) begin
        smpQ   <= '0;
        mantQ  <= '0;
        shiftQ <= SHIFT_W'(SHIFT_BASE);
        zeroQ  <= 1'b1;
      end else if (cmd.take) begin
        smpQ   <= $signed(inSmp[ch]);
        mantQ  <= decMant;
        shiftQ <= decShift;
        zeroQ  <= decMute | ~cmd.ena[ch];
      end
    end

    // Stage 2 arithmetic: multiply, round half up, shift, saturate
    always_comb begin
      smpExt  = PROD_W'(smpQ);
      mantExt = PROD_W'(mantQ);
      prod    = smpExt * mantExt;
      bias    = PROD_W'(1) << (shiftQ - SHIFT_W'(1));
      sum     = prod + bias;
      scaled  = sum >>> shiftQ;
      if (zeroQ)                result = '0;
      else if (scaled > SAT_HI) result = SAT_HI[SAMPLE_W-1:0];
      else if (scaled < SAT_LO) result = SAT_LO[SAMPLE_W-1:0];
      else                      result = scaled[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN)           outSmp[ch] <= '0;
      else if (stageValid) outSmp[ch] <= result;
    end
  end
endmodule

// File: rtl/stereo_volume.sv
`timescale 1ns/1ps
module stereo_volume
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                leftWr,
  input  logic                leftWrEna,
  input  logic                leftWrUpd,
  input  logic [7:0]          leftWrCode,
  input  logic                rightWr,
  input  logic                rightWrEna,
  input  logic                rightWrUpd,
  input  logic [7:0]          rightWrCode,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);
  logic [NUM_CH-1:0] wrStb;
  logic [NUM_CH-1:0] wrEna;
  logic [NUM_CH-1:0] wrUpd;
  logic [NUM_CH-1:0][CODE_W-1:0] wrCode;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] inSmp;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] outSmp;
  logic [NUM_CH-1:0][CODE_W-1:0] activeCode;
  logic pending;
  volCmd_t cmd;

  always_comb begin
    wrStb  = {rightWr, leftWr};
    wrEna  = {rightWrEna, leftWrEna};
    wrUpd  = {rightWrUpd, leftWrUpd};
    wrCode = {rightWrCode, leftWrCode};
    inSmp  = {inRight, inLeft};
    outLeft  = outSmp[0];
    outRight = outSmp[1];
  end

  vol_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .wrEna     (wrEna),
    .wrUpd     (wrUpd),
    .wrCode    (wrCode),
    .sampleStb (inValid),
    .cmd       (cmd),
    .activeCode(activeCode),
    .pending   (pending)
  );

  vol_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .inSmp   (inSmp),
    .outValid(outValid),
    .outSmp  (outSmp)
  );
endmodule

// File: rtl/stereo_volume_chk.sv
`timescale 1ns/1ps
module stereo_volume_chk
  import vol_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                leftWr,
  input logic                leftWrUpd,
  input logic                rightWr,
  input logic                rightWrUpd,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outLeft,
  input logic [SAMPLE_W-1:0] outRight,
  input volCmd_t             cmd,
  input logic [CODE_W-1:0]   activeL,
  input logic [CODE_W-1:0]   activeR,
  input logic                pending
);
  logic updSeen;
  always_comb updSeen = (leftWr & leftWrUpd) | (rightWr & rightWrUpd);

  assert_out_follows_in_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  assert_out_has_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  assert_mute_left_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cmd.code[0] == MUTE_CODE) |=> ##1 (outLeft == '0));

  assert_mute_right_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cmd.code[1] == MUTE_CODE) |=> ##1 (outRight == '0));

  assert_disabled_left_R12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cmd.ena[0]) |=> ##1 (outLeft == '0));

  assert_disabled_right_R12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !cmd.ena[1]) |=> ##1 (outRight == '0));

  assert_hold_without_update_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pending |=> ($stable(activeL) && $stable(activeR)));

  assert_joint_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && pending) |=> (activeL == $past(cmd.code[0]) && activeR == $past(cmd.code[1])));

  assert_change_on_sample_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeL) || !$stable(activeR)) |-> $past(inValid));

  assert_strobe_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && pending && !updSeen) |=> !pending);
endmodule

bind stereo_volume stereo_volume_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .leftWr    (leftWr),
  .leftWrUpd (leftWrUpd),
  .rightWr   (rightWr),
  .rightWrUpd(rightWrUpd),
  .outValid  (outValid),
  .outLeft   (outLeft),
  .outRight  (outRight),
  .cmd       (cmd),
  .activeL   (activeCode[0]),
  .activeR   (activeCode[1]),
  .pending   (pending)
);

// File: tb/stereo_volume_tb.sv
`timescale 1ns/1ps
module stereo_volume_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic leftWr = 0, leftWrEna = 0, leftWrUpd = 0;
  logic [7:0] leftWrCode = '0;
  logic rightWr = 0, rightWrEna = 0, rightWrUpd = 0;
  logic [7:0] rightWrCode = '0;
  logic inValid = 0;
  logic [W-1:0] inLeft = '0, inRight = '0;
  logic outValid;
  logic [W-1:0] outLeft, outRight;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stereo_volume #(.SAMPLE_W(W)) u_dut (
    .clk(clk), .rstN(rstN),
    .leftWr(leftWr), .leftWrEna(leftWrEna), .leftWrUpd(leftWrUpd), .leftWrCode(leftWrCode),
    .rightWr(rightWr), .rightWrEna(rightWrEna), .rightWrUpd(rightWrUpd), .rightWrCode(rightWrCode),
    .inValid(inValid), .inLeft(inLeft), .inRight(inRight),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight)
  );

  function automatic longint mantOf(int k);
    return longint'($rtoi(2.0 ** (k / 16.0) * 16384.0 + 0.5));
  endfunction

  // Expected output from the gain law of R4, R5, R6, R7, R12
  function automatic longint expOut(int code, bit ena, longint x);
    int c, s;
    longint p, r, hiLim, loLim;
    if (!ena || code == 0) return 0;
    c = (code > 239) ? 239 : code;
    s = 26 - (c >> 4);
    p = x * mantOf(c & 15);
    r = (p + (longint'(1) <<< (s - 1))) >>> s;
    hiLim = (longint'(1) <<< (W - 1)) - 1;
    loLim = -(longint'(1) <<< (W - 1));
    if (r > hiLim) r = hiLim;
    if (r < loLim) r = loLim;
    return r;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered and left at a falling edge
  task automatic wrCh(input bit doL, input int cL, input bit eL, input bit uL,
                      input bit doR, input int cR, input bit eR, input bit uR);
    leftWr = doL; leftWrCode = 8'(cL); leftWrEna = eL; leftWrUpd = uL;
    rightWr = doR; rightWrCode = 8'(cR); rightWrEna = eR; rightWrUpd = uR;
    @(negedge clk);
    leftWr = 0; leftWrUpd = 0; rightWr = 0; rightWrUpd = 0;
  endtask

  task automatic sample(input longint xl, input longint xr,
                        input longint eL, input longint eR, input string req);
    inValid = 1; inLeft = W'(xl); inRight = W'(xr);
    @(negedge clk);
    inValid = 0;
    chk("R3 early", longint'(outValid), 0);
    @(negedge clk);
    chk("R3 valid", longint'(outValid), 1);
    chk({req, " left"}, longint'($signed(outLeft)), eL);
    chk({req, " right"}, longint'($signed(outRight)), eR);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    longint xs[7];
    xs[0] = 32767; xs[1] = -32768; xs[2] = 1; xs[3] = -1;
    xs[4] = 1000; xs[5] = -12345; xs[6] = 0;

    repeat (3) @(negedge clk);
    chk("R1 valid in reset", longint'(outValid), 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 valid", longint'(outValid), 0);
    chk("R1 left", longint'(outLeft), 0);
    chk("R1 right", longint'(outRight), 0);

    // R12: enables default low
    sample(1000, -1000, 0, 0, "R12 default disabled");

    // R2 and R8: enable, stage other codes without update -> unity
    wrCh(1, 8'h10, 1, 0, 1, 8'h20, 1, 0);
    sample(1234, -4321, 1234, -4321, "R2 R8 unity before update");

    // R4 R5 R6 R7: every code on both channels
    for (int c = 0; c < 256; c++) begin
      wrCh(1, c, 1, 1, 1, 255 - c, 1, 0);
      for (int i = 0; i < 7; i++) begin
        sample(xs[i], xs[6 - i], expOut(c, 1, xs[i]), expOut(255 - c, 1, xs[6 - i]),
               "R4 R5 R6 R7 sweep");
      end
    end
    // active now: left 0xFF, right 0x00
    sample(32767, 5, 32767, 0, "R5 clamp high, R6 mute");
    sample(-32768, 5, -32768, 0, "R5 clamp low");
    sample(100, 5, expOut(8'hEF, 1, 100), 0, "R7 above top code");

    // R8 and R9: stage left, then update through the right channel only
    wrCh(1, 8'hA0, 1, 0, 0, 0, 0, 0);
    sample(2000, 2000, expOut(8'hFF, 1, 2000), 0, "R8 staged only");
    wrCh(0, 0, 0, 0, 1, 8'h80, 1, 1);
    sample(2000, 2000, expOut(8'hA0, 1, 2000), expOut(8'h80, 1, 2000), "R9 joint commit");

    // R11: no further update -> staged writes stay dormant
    wrCh(1, 8'h40, 1, 0, 1, 8'h40, 1, 0);
    sample(-3000, 3000, expOut(8'hA0, 1, -3000), expOut(8'h80, 1, 3000), "R11 self-clear");

    // R10: update request in the same cycle as a sample
    leftWr = 1; leftWrCode = 8'hC0; leftWrEna = 1; leftWrUpd = 1;
    inValid = 1; inLeft = W'(7000); inRight = W'(7000);
    @(negedge clk);
    leftWr = 0; leftWrUpd = 0; inValid = 0;
    @(negedge clk);
    chk("R10 same-cycle valid", longint'(outValid), 1);
    chk("R10 same-cycle left old", longint'($signed(outLeft)), expOut(8'hA0, 1, 7000));
    chk("R10 same-cycle right old", longint'($signed(outRight)), expOut(8'h80, 1, 7000));
    sample(7000, 7000, 7000, expOut(8'h40, 1, 7000), "R10 next sample new");

    // R12: disable in the same cycle as a sample, then later sample
    leftWr = 1; leftWrCode = 8'hC0; leftWrEna = 0; leftWrUpd = 0;
    inValid = 1; inLeft = W'(-500); inRight = W'(-500);
    @(negedge clk);
    leftWr = 0; inValid = 0;
    @(negedge clk);
    chk("R12 same-cycle left still enabled", longint'($signed(outLeft)), -500);
    sample(-500, -500, 0, expOut(8'h40, 1, -500), "R12 disabled later");
    @(negedge clk);
    chk("R3 idle", longint'(outValid), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule